// File: doc/BRIEF.md
# Loopback Self-Test Controller for a Serial Link

This block is the digital half of a serializer/deserializer self-test. It picks one of four loopback paths, drives the parallel transmit word, and judges what comes back on the parallel receive word. Each path isolates a different stretch of the physical layer. A run that fails in one path and passes in another points to the section between them.

Two modes send a pseudo-random pattern and check it on return. These are the parallel path, closed at the digital interface, and the serial path, closed behind the serializer. In the echo mode, received words go straight back out to the transmit side, and the checker judges the stream that arrives. In the clock mode, no data is checked. The recovered-clock indication is copied onto every transmit bit, and the run passes if that indication toggles within a window.

The checker aligns itself to the returned stream, so any loop latency is accepted. At the end of every run it reports pass/fail and an error count. It also stores that result in a four-entry table with one entry per mode, which can be read at any time.

Top module: `lbk_bist_ctrl`

## Requirements
- R1: After reset: busy, done, run_pass and run_err are 0, path_sel is 0, tx_word is 0 while mode_sel selects a pattern mode, and every table entry reads rd_valid = 0.
- R2: mode_sel encodes 0 = echo, 1 = clock, 2 = parallel pattern, 3 = serial pattern. Each cycle tx_word takes rx_word (echo), the replicated rx_clk_in (clock) or the pattern (modes 2 and 3). While a run is busy, path_sel is one-hot with bit index equal to the run's mode; otherwise path_sel is 0.
- R3: The pattern comes from a 7-bit register with polynomial x^7 + x^6 + 1. The register starts at all ones, and each step shifts left with new bit = bit6 XOR bit5 entering at bit 0. Each word holds 10 consecutive new bits, the first at the MSB. Word 0 appears on tx_word the cycle after the start is accepted. In modes 2 and 3, tx_word is 0 while idle.
- R4: After the start, the first nonzero rx_word is the lock word. Its 7 LSBs seed the checker, and the lock word itself is not counted.
- R5: After the lock word, the next run_len words (0 counts as 1) are compared, and run_err is the total of mismatched bits. The run ends on the edge that compares the last word. done pulses for one cycle in the next cycle, with run_pass and run_err valid there.
- R6: run_pass is 1 exactly when the error total is 0. The total saturates at all ones.
- R7: If no nonzero word arrives within LOCK_WIN cycles after the start, the run ends with run_pass = 0 and run_err = 0.
- R8: In clock mode, the run passes (error 0) on the first cycle where rx_clk_in differs from its value one cycle earlier, provided this happens within CLK_WIN cycles after the start. Otherwise it fails with error 1 after CLK_WIN cycles.
- R9: A start while busy is ignored: the run keeps its mode, length and timing.
- R10: At the end of a run, the entry of that run's mode takes {valid, pass, error}; the other entries keep their contents. rd_valid, rd_pass and rd_err show the entry chosen by rd_mode one cycle later.
- R11: In echo mode, rx_word is locked and checked exactly as in R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Loopback mode for the next run |
| start | input | 1 | Begin a run (taken only when idle) |
| run_len | input | LEN_W | Words to compare after lock |
| rx_word | input | WORD_W | Parallel word from the deserializer |
| rx_clk_in | input | 1 | Recovered-clock indication |
| tx_word | output | WORD_W | Parallel word to the serializer |
| path_sel | output | 4 | One-hot loop path control while busy |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| run_pass | output | 1 | Pass flag of the last run |
| run_err | output | ERR_W | Error total of the last run |
| rd_mode | input | 2 | Table entry to read |
| rd_valid | output | 1 | Entry holds a result |
| rd_pass | output | 1 | Entry pass flag |
| rd_err | output | ERR_W | Entry error total |

## Verification
The bench builds the block with a 10-bit word, an 8-bit run length, a 5-bit error total and both windows set to 16 cycles. With these values the saturation point (31) is reached by four fully inverted words. The short windows let the toggle boundary at cycles 16 and 17 and the lock timeout be swept cheaply. Loop latency is swept from 0 to 3 cycles, and the bench checks the end-of-run cycle against 3 + length + latency.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic [1:0] {
    MD_IO   = 2'd0,
    MD_RCLK = 2'd1,
    MD_PAR  = 2'd2,
    MD_SER  = 2'd3
  } lbk_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOCK,
    ST_CHECK,
    ST_CLKW
  } lbk_state_e;

  localparam logic [6:0] PRBS_SEED = 7'h7F;

  // one shift of the x^7 + x^6 + 1 register, new bit enters at bit 0
  function automatic logic [6:0] prbs7_step(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

endpackage

// File: rtl/lbk_prbs_step.sv
module lbk_prbs_step
  import lbk_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [6:0]        cur,
  output logic [WORD_W-1:0] word,
  output logic [6:0]        nxt
);
  logic [6:0] s;

  always_comb begin
    s    = cur;
    word = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      s       = prbs7_step(s);
      word[i] = s[0];
    end
    nxt = s;
  end
endmodule

// File: rtl/lbk_prbs_gen.sv
module lbk_prbs_gen
  import lbk_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [WORD_W-1:0] pat
);
  logic [6:0] st, st_nxt;

  lbk_prbs_step #(.WORD_W(WORD_W)) u_step (
    .cur (st),
    .word(pat),
    .nxt (st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || load) st <= PRBS_SEED;
    else if (adv)    st <= st_nxt;
  end
endmodule

// File: rtl/lbk_checker.sv
module lbk_checker
  import lbk_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              lock_en,
  input  logic              chk_en,
  input  logic [WORD_W-1:0] rx_word,
  output logic              lock_hit,
  output logic [ERR_W-1:0]  err_acc,
  output logic [ERR_W-1:0]  err_upd
);
  localparam int PC_W  = $clog2(WORD_W + 1);
  localparam int SUM_W = ((ERR_W > PC_W) ? ERR_W : PC_W) + 1;

  logic [6:0]        ref_st, ref_nxt;
  logic [WORD_W-1:0] ref_word, diff;
  logic [PC_W-1:0]   pc;
  logic [SUM_W-1:0]  sum;

  lbk_prbs_step #(.WORD_W(WORD_W)) u_ref (
    .cur (ref_st),
    .word(ref_word),
    .nxt (ref_nxt)
  );

  assign diff     = rx_word ^ ref_word;
  assign lock_hit = lock_en && (rx_word != '0);

  always_comb begin
    pc = '0;
    for (int i = 0; i < WORD_W; i++) pc = pc + PC_W'(diff[i]);
  end

  assign sum = SUM_W'(err_acc) + SUM_W'(pc);

  always_comb begin
    if (!chk_en)                             err_upd = err_acc;
    else if (sum > SUM_W'({ERR_W{1'b1}}))    err_upd = '1;
    else                                     err_upd = sum[ERR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_st  <= PRBS_SEED;
      err_acc <= '0;
    end else begin
      if (clr)         err_acc <= '0;
      else if (chk_en) err_acc <= err_upd;
      if (lock_hit)    ref_st <= rx_word[6:0];
      else if (chk_en) ref_st <= ref_nxt;
    end
  end

  // R5/R6: the running total never goes down within a run
  a_r5_err_monotone: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !clr) |=> (err_acc >= $past(err_acc)));
endmodule

// File: rtl/lbk_status_tbl.sv
module lbk_status_tbl #(
  parameter int ERR_W   = 16,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_pass,
  input  logic [ERR_W-1:0] wr_err,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_pass,
  output logic [ERR_W-1:0] rd_err
);
  logic [ERR_W:0]     mem [ENTRIES];
  logic [ENTRIES-1:0] valid;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_pass, wr_err};
    {rd_pass, rd_err} <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid[wr_idx] <= 1'b1;
      rd_valid <= valid[rd_idx];
    end
  end

  // R10: a written entry reads as holding a result afterwards
  a_r10_entry_valid: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid[$past(wr_idx)]);
endmodule

// File: rtl/lbk_bist_ctrl.sv
module lbk_bist_ctrl
  import lbk_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LEN_W    = 16,
  parameter int ERR_W    = 16,
  parameter int LOCK_WIN = 64,
  parameter int CLK_WIN  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              start,
  input  logic [LEN_W-1:0]  run_len,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_clk_in,
  output logic [WORD_W-1:0] tx_word,
  output logic [3:0]        path_sel,
  output logic              busy,
  output logic              done,
  output logic              run_pass,
  output logic [ERR_W-1:0]  run_err,
  input  logic [1:0]        rd_mode,
  output logic              rd_valid,
  output logic              rd_pass,
  output logic [ERR_W-1:0]  rd_err
);
  localparam int WIN_MAX = (LOCK_WIN > CLK_WIN) ? LOCK_WIN : CLK_WIN;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int CNT_W   = (LEN_W > WIN_W) ? LEN_W : WIN_W;

  lbk_state_e        state, state_n;
  lbk_mode_e         mode_r, cmode;
  logic [LEN_W-1:0]  len_r;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [CNT_W:0]    cnt_inc;
  logic              clk_q, toggle, last_word;
  logic              start_ok, gen_adv, lock_en, chk_en, lock_hit;
  logic              fin, fin_pass;
  logic [ERR_W-1:0]  fin_err, err_acc, err_upd;
  logic [WORD_W-1:0] gen_pat;

  assign busy      = (state != ST_IDLE);
  assign start_ok  = start && !busy;
  assign cmode     = busy ? mode_r : lbk_mode_e'(mode_sel);
  assign gen_adv   = busy && (mode_r == MD_PAR || mode_r == MD_SER);
  assign lock_en   = (state == ST_LOCK);
  assign chk_en    = (state == ST_CHECK);
  assign toggle    = (rx_clk_in != clk_q);
  assign cnt_inc   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign last_word = (cnt_inc >= (CNT_W + 1)'(len_r));
  assign path_sel  = busy ? (4'b0001 << mode_r) : 4'b0000;

  lbk_prbs_gen #(.WORD_W(WORD_W)) u_gen (
    .clk (clk),
    .rst (rst),
    .load(start_ok),
    .adv (gen_adv),
    .pat (gen_pat)
  );

  lbk_checker #(.WORD_W(WORD_W), .ERR_W(ERR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (start_ok),
    .lock_en (lock_en),
    .chk_en  (chk_en),
    .rx_word (rx_word),
    .lock_hit(lock_hit),
    .err_acc (err_acc),
    .err_upd (err_upd)
  );

  lbk_status_tbl #(.ERR_W(ERR_W), .ENTRIES(4)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fin),
    .wr_idx  (mode_r),
    .wr_pass (fin_pass),
    .wr_err  (fin_err),
    .rd_idx  (rd_mode),
    .rd_valid(rd_valid),
    .rd_pass (rd_pass),
    .rd_err  (rd_err)
  );

  // run sequencing: lock, count words, or wait for a clock edge
  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    fin      = 1'b0;
    fin_pass = 1'b0;
    fin_err  = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          state_n = (lbk_mode_e'(mode_sel) == MD_RCLK) ? ST_CLKW : ST_LOCK;
          cnt_n   = '0;
        end
      end
      ST_LOCK: begin
        if (lock_hit) begin
          state_n = ST_CHECK;
          cnt_n   = '0;
        end else if (cnt == CNT_W'(LOCK_WIN - 1)) begin
          state_n = ST_IDLE;
          fin     = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_CHECK: begin
        if (last_word) begin
          state_n  = ST_IDLE;
          fin      = 1'b1;
          fin_pass = (err_upd == '0);
          fin_err  = err_upd;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_CLKW: begin
        if (toggle) begin
          state_n  = ST_IDLE;
          fin      = 1'b1;
          fin_pass = 1'b1;
        end else if (cnt == CNT_W'(CLK_WIN - 1)) begin
          state_n = ST_IDLE;
          fin     = 1'b1;
          fin_err = ERR_W'(1);
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_r   <= MD_IO;
      len_r    <= '0;
      cnt      <= '0;
      clk_q    <= 1'b0;
      tx_word  <= '0;
      done     <= 1'b0;
      run_pass <= 1'b0;
      run_err  <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      clk_q <= rx_clk_in;
      done  <= fin;
      if (start_ok) begin
        mode_r <= lbk_mode_e'(mode_sel);
        len_r  <= run_len;
      end
      if (fin) begin
        run_pass <= fin_pass;
        run_err  <= fin_err;
      end
      case (cmode)
        MD_IO:   tx_word <= rx_word;
        MD_RCLK: tx_word <= {WORD_W{rx_clk_in}};
        default: tx_word <= busy ? gen_pat : '0;
      endcase
    end
  end

  // R2: echo path copies the receive word one cycle later
  a_r2_io_echo: assert property (@(posedge clk) disable iff (rst)
    (cmode == MD_IO) |=> (tx_word == $past(rx_word)));
  // R2: clock path replicates the recovered-clock indication
  a_r2_clk_echo: assert property (@(posedge clk) disable iff (rst)
    (cmode == MD_RCLK) |=> (tx_word == {WORD_W{$past(rx_clk_in)}}));
  // R3: pattern modes keep the transmit word quiet while idle
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && mode_sel[1]) |=> (tx_word == '0));
  // R4: comparison starts only after a lock cycle
  a_r4_enter_check: assert property (@(posedge clk) disable iff (rst)
    $rose(chk_en) |-> $past(lock_en));
  // R5: end-of-run indication lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: a passing run reports a zero total
  a_r6_pass_zero: assert property (@(posedge clk) disable iff (rst)
    (done && run_pass) |-> (run_err == '0));
  // R9: the mode of a run stays fixed until it ends
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(mode_r)));
endmodule

// File: tb/lbk_bist_ctrl_tb_top.sv
module lbk_bist_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 10;
  localparam int LEN_W = 8;
  localparam int ERR_W = 5;
  localparam int WIN   = 16;
  localparam int EMAX  = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  logic rst, start, rx_clk_in;
  logic [1:0] mode_sel, rd_mode;
  logic [LEN_W-1:0] run_len;
  logic [W-1:0] rx_word, tx_word;
  logic [3:0] path_sel;
  logic busy, done, run_pass, rd_valid, rd_pass;
  logic [ERR_W-1:0] run_err, rd_err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lbk_bist_ctrl #(.WORD_W(W), .LEN_W(LEN_W), .ERR_W(ERR_W),
                  .LOCK_WIN(WIN), .CLK_WIN(WIN)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .start(start), .run_len(run_len),
    .rx_word(rx_word), .rx_clk_in(rx_clk_in), .tx_word(tx_word), .path_sel(path_sel),
    .busy(busy), .done(done), .run_pass(run_pass), .run_err(run_err),
    .rd_mode(rd_mode), .rd_valid(rd_valid), .rd_pass(rd_pass), .rd_err(rd_err)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // reference pattern words built bit by bit from the polynomial
  logic [W-1:0] exp_w [0:15];
  initial begin
    logic [6:0] s;
    logic nb;
    s = 7'h7F;
    for (int k = 0; k < 16; k++) begin
      for (int i = W - 1; i >= 0; i--) begin
        nb = s[6] ^ s[5];
        exp_w[k][i] = nb;
        s = {s[5:0], nb};
      end
    end
  end

  // loop model: delay line with error injection by returned-word index
  logic [W-1:0] sh [0:7];
  int lat = 0;
  int rx_cnt = 0;
  int inj_f = 0;
  int inj_n = 0;
  logic [W-1:0] inj_mask = '0;
  logic new_run = 1'b0;
  logic kill = 1'b0;
  logic src_ext = 1'b0;
  logic [W-1:0] ext_word = '0;
  logic [W-1:0] raw, inj;

  always_ff @(posedge clk) begin
    sh[0] <= tx_word;
    for (int i = 1; i < 8; i++) sh[i] <= sh[i-1];
    if (new_run)          rx_cnt <= 0;
    else if (raw != '0)   rx_cnt <= rx_cnt + 1;
  end

  assign raw = (lat == 0) ? tx_word : sh[lat-1];
  assign inj = (raw != '0 && rx_cnt >= inj_f && rx_cnt < inj_f + inj_n) ? inj_mask : '0;
  assign rx_word = src_ext ? ext_word : (kill ? '0 : (raw ^ inj));

  int tv[4], tp[4], te[4];

  function automatic int popc(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int exp_err(input int m, input int len, input int f, input int n);
    int leff = (len == 0) ? 1 : len;
    int hits = 0;
    int e;
    for (int i = f; i < f + n; i++) if (i >= 1 && i <= leff) hits++;
    e = m * hits;
    return (e > EMAX) ? EMAX : e;
  endfunction

  task automatic finish_run(input int m, input int p, input int e);
    tv[m] = 1; tp[m] = p; te[m] = e;
    repeat (12) @(negedge clk);
  endtask

  task automatic run_pat(input int mode, input int lat_i, input int len, input int f,
                         input int n, input logic [W-1:0] mask, input bit poke);
    int cnt = 0;
    int leff = (len == 0) ? 1 : len;
    int e = exp_err(popc(mask), len, f, n);
    src_ext = 0; kill = 0; lat = lat_i;
    inj_f = f; inj_n = n; inj_mask = mask;
    mode_sel = 2'(mode); run_len = LEN_W'(len);
    @(negedge clk);
    start = 1; new_run = 1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin start = 0; new_run = 0; end
      if (poke && cnt == 4) begin start = 1; mode_sel = 2'd1; end
      if (poke && cnt == 5) begin start = 0; mode_sel = 2'(mode); end
      if (cnt >= 2 && cnt <= 4 && cnt - 2 <= leff)
        chk($sformatf("R3 pattern word %0d", cnt - 2), int'(tx_word), int'(exp_w[cnt-2]));
      if (cnt == 2) chk("R2 path_sel one-hot", int'(path_sel), 1 << mode);
    end while (!done && cnt < 400);
    chk($sformatf("R5 end cycle lat=%0d len=%0d%s", lat_i, len, poke ? " R9 poke" : ""),
        cnt, 3 + leff + lat_i);
    chk("R5 error total", int'(run_err), e);
    chk("R6 pass flag", int'(run_pass), (e == 0) ? 1 : 0);
    finish_run(mode, (e == 0) ? 1 : 0, e);
  endtask

  task automatic run_io(input int len, input int f, input logic [W-1:0] mask);
    bit got = 0;
    int e = exp_err(popc(mask), len, f, 1);
    logic [W-1:0] w;
    src_ext = 1; mode_sel = 2'd0; run_len = LEN_W'(len); ext_word = '0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int j = 0; j < len + 6 && !got; j++) begin
      w = (j >= 2 && j - 2 <= len + 1) ? (exp_w[j-2] ^ ((j - 2 == f) ? mask : '0)) : '0;
      ext_word = w;
      @(negedge clk);
      if (j == 3) chk("R2 echo of receive word", int'(tx_word), int'(w));
      if (done) got = 1;
    end
    chk("R11 echo run finished", int'(got), 1);
    chk("R11 echo error total", int'(run_err), e);
    chk("R11 echo pass flag", int'(run_pass), (e == 0) ? 1 : 0);
    src_ext = 0; ext_word = '0;
    finish_run(0, (e == 0) ? 1 : 0, e);
  endtask

  task automatic run_clk(input int m);
    int cnt = 0;
    int p = (m >= 1 && m <= WIN) ? 1 : 0;
    mode_sel = 2'd1;
    @(negedge clk); start = 1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        start = 0;
        chk("R2 clock replicated", int'(tx_word), rx_clk_in ? (1 << W) - 1 : 0);
      end
      if (cnt == m) rx_clk_in = ~rx_clk_in;
    end while (!done && cnt < 400);
    chk($sformatf("R8 end cycle toggle@%0d", m), cnt, p ? m + 1 : WIN + 1);
    chk($sformatf("R8 pass toggle@%0d", m), int'(run_pass), p);
    chk($sformatf("R8 error toggle@%0d", m), int'(run_err), p ? 0 : 1);
    finish_run(1, p, p ? 0 : 1);
  endtask

  task automatic run_kill();
    int cnt = 0;
    kill = 1; mode_sel = 2'd2; run_len = 8'd4;
    @(negedge clk); start = 1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) start = 0;
    end while (!done && cnt < 400);
    chk("R7 lock timeout cycle", cnt, WIN + 1);
    chk("R7 lock timeout pass", int'(run_pass), 0);
    chk("R7 lock timeout error", int'(run_err), 0);
    kill = 0;
    finish_run(2, 0, 0);
  endtask

  task automatic rd_tbl(input int m);
    @(negedge clk); rd_mode = 2'(m);
    @(negedge clk);
    chk($sformatf("R10 valid mode %0d", m), int'(rd_valid), tv[m]);
    if (tv[m] != 0) begin
      chk($sformatf("R10 pass mode %0d", m), int'(rd_pass), tp[m]);
      chk($sformatf("R10 error mode %0d", m), int'(rd_err), te[m]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin tv[m] = 0; tp[m] = 0; te[m] = 0; end
    rst = 1; start = 0; rx_clk_in = 0; mode_sel = 2'd2; rd_mode = 2'd0; run_len = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset tx_word", int'(tx_word), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset run_pass", int'(run_pass), 0);
    chk("R1 reset run_err", int'(run_err), 0);
    chk("R1 reset path_sel", int'(path_sel), 0);
    for (int m = 0; m < 4; m++) rd_tbl(m);

    // R4 R5: latency sweep, clean loops in both pattern modes
    for (int l = 0; l < 4; l++) run_pat(2, l, 8, 0, 0, '0, 0);
    for (int l = 0; l < 4; l++) run_pat(3, l, 5, 0, 0, '0, 0);
    run_pat(2, 2, 8, 3, 1, 10'h004, 0);
    run_pat(2, 1, 6, 2, 3, 10'h111, 0);
    run_pat(3, 3, 8, 8, 2, 10'h030, 0);
    run_pat(3, 1, 1, 1, 1, 10'h3FF, 0);
    run_pat(3, 0, 0, 1, 1, 10'h201, 0);
    run_pat(3, 2, 8, 1, 4, 10'h3FF, 0);

    run_io(6, 2, 10'h081);
    run_io(4, 0, 10'h000);

    run_clk(1);
    run_clk(WIN);
    run_clk(WIN + 1);
    run_clk(0);

    run_kill();
    run_pat(2, 1, 8, 0, 0, '0, 1);

    for (int m = 0; m < 4; m++) rd_tbl(m);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule